// File: doc/BRIEF.md
# Serial USART Transmitter with Sync Fill

This block is the transmit half of a USART. A CPU-side write strobe places one character into a holding buffer. When the serial shifter has nothing to send, the held character is framed and moved into the shifter. The shifter then sends it one bit per pulse of a transmit bit-rate enable. That enable belongs to the transmit side alone, so the receive side may run at another rate. Bits go out least significant first. Two flags report progress: `txRdy` means the buffer can take a character, and `txEmpty` means both the buffer and the shifter are empty.

In asynchronous mode each character gets a low start bit, 5 to 8 data bits, an optional even or odd parity bit, and one or two high stop bits. The line rests high between characters. In synchronous mode a character is the data bits plus optional parity, with no start or stop bits. If the CPU has not supplied the next character when one finishes, the block sends a programmed sync character, or a pair of them, to keep the line busy. It marks that gap with a one-clock pulse on `txEmpty`.

A clear-to-send input (active low) and an enable input together gate transmission. Closing the gate never cuts a character short. The character in the shifter finishes, and a character waiting in the buffer stays there until the gate opens again.

Top module: `usart_tx`

## Requirements
- R1: While and after reset, with no write and no bit pulse, `txd` is 1, `txRdy` is 1 and `txEmpty` is 1.
- R2: In asynchronous mode (`syncMode`=0) a character is sent as a 0 start bit, then 5+`charLen` data bits least significant first (`charLen` 0..3 gives 5..8 bits), then the parity bit if enabled, then one stop bit of 1, or two when `twoStop`=1.
- R3: With `parityEn`=1 the parity bit is the XOR of the sent data bits when `parityOdd`=0 (even), and its inverse when `parityOdd`=1 (odd). It is omitted when `parityEn`=0.
- R4: `txd` changes only in the clock after a `bitTick` pulse, so each bit stays on the line for one whole tick interval.
- R5: `txRdy` falls in the clock after an accepted write. It rises again in the clock after the `bitTick` that moves the character into the shifter.
- R6: A write while `txRdy` is 0 is ignored: the held character is kept and the new one is never sent.
- R7: A character waiting in the buffer starts, with its first bit, on the same `bitTick` that ends the last bit of the previous character, leaving no idle bit between them.
- R8: While `ctsN` is 1 or `txEnable` is 0, a character already being shifted completes, no new character starts, the line stays at 1, and a waiting character is kept and sent once the gate opens.
- R9: When the buffer and the shifter are both empty, `txEmpty` is 1. In asynchronous mode the line is at 1 whenever `txEmpty` is 1.
- R10: In synchronous mode a character is 5+`charLen` data bits least significant first, plus the parity bit of R3 if enabled, with no start or stop bits.
- R11: In synchronous mode, when a character ends with the buffer empty and the gate open, `syncChar1` (framed as in R10) starts on that same tick, and `txEmpty` is 1 for exactly one clock.
- R12: With `dualSync`=1 a fill sends `syncChar1` and then `syncChar2` back to back. A character written during the fill is sent after `syncChar2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | CPU write strobe for the holding buffer |
| wrData | input | 8 | Character to transmit |
| bitTick | input | 1 | Transmit bit-rate enable, one pulse per bit time |
| txEnable | input | 1 | Transmitter enable command |
| ctsN | input | 1 | Clear to send, active low |
| syncMode | input | 1 | 1 selects synchronous mode, 0 asynchronous mode |
| charLen | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 even parity |
| twoStop | input | 1 | Two stop bits in asynchronous mode |
| dualSync | input | 1 | Fill with two sync characters instead of one |
| syncChar1 | input | 8 | First sync fill character |
| syncChar2 | input | 8 | Second sync fill character |
| txd | output | 1 | Serial output |
| txRdy | output | 1 | Holding buffer can accept a character |
| txEmpty | output | 1 | Buffer and shifter empty; one-clock pulse on sync fill |

## Verification
Some properties are checked on every cycle: the line moves only after a bit pulse, an accepted write takes the buffer slot, a full buffer stays full without a tick, and an idle asynchronous line rests high whether or not the gate is open. The bench scenarios are needed for the rest: the exact bit order of every frame under each length, parity and stop setting, gap-free chaining of characters, keeping a waiting character while clear-to-send is withdrawn, and the order and one-clock empty pulse of sync fill.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

  localparam int DATA_W   = 8;
  localparam int MIN_BITS = 5;
  localparam int FRAME_W  = DATA_W + 4;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic       syncMode;
    logic [1:0] charLen;
    logic       parityEn;
    logic       parityOdd;
    logic       twoStop;
  } txCfg_t;

  typedef struct packed {
    logic takeWrite;
    logic loadData;
    logic loadSync1;
    logic loadSync2;
    logic shift;
  } txStrobe_t;

  function automatic logic [CNT_W-1:0] frameLen(input txCfg_t c);
    int n;
    n = MIN_BITS + int'(c.charLen) + int'(c.parityEn);
    if (!c.syncMode) n = n + 2 + int'(c.twoStop);
    return CNT_W'(n);
  endfunction

  function automatic logic [FRAME_W-1:0] buildFrame(input logic [DATA_W-1:0] d,
                                                    input txCfg_t c);
    logic [DATA_W-1:0]  mask;
    logic [DATA_W-1:0]  masked;
    logic [FRAME_W-1:0] payload;
    int nBits;
    int payLen;
    nBits   = MIN_BITS + int'(c.charLen);
    mask    = {DATA_W{1'b1}} >> (DATA_W - nBits);
    masked  = d & mask;
    payload = FRAME_W'(masked);
    if (c.parityEn) payload[nBits] = (^masked) ^ c.parityOdd;
    payLen  = nBits + int'(c.parityEn);
    if (c.syncMode) return payload;
    return ({FRAME_W{1'b1}} << (payLen + 1)) | (payload << 1);
  endfunction

endpackage

// File: rtl/usart_tx_ctrl.sv
module usart_tx_ctrl
  import usart_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      bitTick,
  input  logic      gateOpen,
  input  logic      dualSync,
  input  txCfg_t    cfg,
  output txStrobe_t strobe,
  output logic      lineActive,
  output logic      txRdy,
  output logic      txEmpty
);

  logic             holdFull;
  logic [CNT_W-1:0] bitsLeft;
  logic             secondPending;
  logic             fillFlag;
  logic             lastBit;
  logic             idle;
  logic             frameEnd;
  logic             fillSlot;

  always_comb begin
    lastBit  = (bitsLeft == CNT_W'(1));
    idle     = (bitsLeft == '0);
    frameEnd = bitTick && (idle || lastBit);
    fillSlot = frameEnd && lastBit && gateOpen && cfg.syncMode;

    strobe.takeWrite = wrEn && !holdFull;
    strobe.loadSync2 = fillSlot && secondPending;
    strobe.loadData  = frameEnd && gateOpen && holdFull && !strobe.loadSync2;
    strobe.loadSync1 = fillSlot && !holdFull && !secondPending;
    strobe.shift     = bitTick && !idle && !lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull      <= 1'b0;
      bitsLeft      <= '0;
      secondPending <= 1'b0;
      fillFlag      <= 1'b0;
    end else begin
      if (strobe.loadData)       holdFull <= 1'b0;
      else if (strobe.takeWrite) holdFull <= 1'b1;

      if (strobe.loadData || strobe.loadSync1 || strobe.loadSync2)
        bitsLeft <= frameLen(cfg);
      else if (strobe.shift)
        bitsLeft <= bitsLeft - CNT_W'(1);
      else if (frameEnd)
        bitsLeft <= '0;

      if (strobe.loadSync1)  secondPending <= dualSync;
      else if (frameEnd)     secondPending <= 1'b0;

      fillFlag <= strobe.loadSync1;
    end
  end

  assign lineActive = !idle;
  assign txRdy      = !holdFull;
  assign txEmpty    = (!holdFull && idle) || fillFlag;

endmodule

// File: rtl/usart_tx_dp.sv
module usart_tx_dp
  import usart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  txCfg_t            cfg,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] syncChar1,
  input  logic [DATA_W-1:0] syncChar2,
  input  logic              lineActive,
  output logic              txd
);

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '1;
    end else begin
      if (strobe.takeWrite) holdReg <= wrData;

      if (strobe.loadData)       shiftReg <= buildFrame(holdReg, cfg);
      else if (strobe.loadSync1) shiftReg <= buildFrame(syncChar1, cfg);
      else if (strobe.loadSync2) shiftReg <= buildFrame(syncChar2, cfg);
      else if (strobe.shift)     shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  assign txd = lineActive ? shiftReg[0] : 1'b1;

endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bitTick,
  input  logic              txEnable,
  input  logic              ctsN,
  input  logic              syncMode,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              dualSync,
  input  logic [DATA_W-1:0] syncChar1,
  input  logic [DATA_W-1:0] syncChar2,
  output logic              txd,
  output logic              txRdy,
  output logic              txEmpty
);

  txCfg_t    cfg;
  txStrobe_t strobe;
  logic      lineActive;
  logic      gateOpen;

  assign cfg      = '{syncMode: syncMode, charLen: charLen, parityEn: parityEn,
                      parityOdd: parityOdd, twoStop: twoStop};
  assign gateOpen = txEnable && !ctsN;

  usart_tx_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .bitTick    (bitTick),
    .gateOpen   (gateOpen),
    .dualSync   (dualSync),
    .cfg        (cfg),
    .strobe     (strobe),
    .lineActive (lineActive),
    .txRdy      (txRdy),
    .txEmpty    (txEmpty)
  );

  usart_tx_dp i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfg        (cfg),
    .wrData     (wrData),
    .syncChar1  (syncChar1),
    .syncChar2  (syncChar2),
    .lineActive (lineActive),
    .txd        (txd)
  );

endmodule

// File: rtl/usart_tx_chk.sv
module usart_tx_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic bitTick,
  input logic txEnable,
  input logic ctsN,
  input logic syncMode,
  input logic txd,
  input logic txRdy,
  input logic txEmpty
);

  // R4
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(txd));

  // R5
  write_takes_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && txRdy |=> !txRdy);

  // R6
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txRdy && !bitTick |=> !txRdy);

  // R8
  gate_closed_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncMode && txEmpty && !wrEn && (ctsN || !txEnable) |=> txEmpty && txd);

  // R9
  empty_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncMode && txEmpty |-> txd);

endmodule

bind usart_tx usart_tx_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .bitTick  (bitTick),
  .txEnable (txEnable),
  .ctsN     (ctsN),
  .syncMode (syncMode),
  .txd      (txd),
  .txRdy    (txRdy),
  .txEmpty  (txEmpty)
);

// File: tb/test_usart_tx.sv
module test_usart_tx;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       bitTick = 1'b0;
  logic       txEnable = 1'b1;
  logic       ctsN = 1'b0;
  logic       syncMode = 1'b0;
  logic [1:0] charLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       twoStop = 1'b0;
  logic       dualSync = 1'b0;
  logic [7:0] syncChar1 = '0;
  logic [7:0] syncChar2 = '0;
  logic       txd;
  logic       txRdy;
  logic       txEmpty;

  int  checks = 0;
  int  fails = 0;
  int  stableErr = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usart_tx i_usart_tx (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .bitTick(bitTick),
    .txEnable(txEnable), .ctsN(ctsN), .syncMode(syncMode), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .twoStop(twoStop),
    .dualSync(dualSync), .syncChar1(syncChar1), .syncChar2(syncChar2),
    .txd(txd), .txRdy(txRdy), .txEmpty(txEmpty)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected frame built bit by bit from the requirement text.
  function automatic void expFrame(input logic [7:0] d, input int cl, input int pm,
                                   input int st, input bit sync,
                                   output logic [11:0] v, output int len);
    int idx = 0;
    int ones = 0;
    v = '1;
    if (!sync) begin v[idx] = 1'b0; idx++; end
    for (int i = 0; i < 5 + cl; i++) begin
      v[idx] = d[i];
      ones += int'(d[i]);
      idx++;
    end
    if (pm != 0) begin
      v[idx] = (pm == 1) ? ((ones % 2) == 1) : ((ones % 2) == 0);
      idx++;
    end
    if (!sync) begin
      for (int s = 0; s < 1 + st; s++) begin v[idx] = 1'b1; idx++; end
    end
    len = idx;
  endfunction

  function automatic logic [11:0] lenMask(input int len);
    return 12'hFFF >> (12 - len);
  endfunction

  task automatic writeByte(input logic [7:0] b);
    wrData = b;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // One tick per bit; sample right after the tick edge and one clock later.
  task automatic recvFrame(input int n, output logic [11:0] got,
                           output logic firstEmpty, output logic firstEmptyLate);
    logic held;
    got = '1;
    firstEmpty = 1'b0;
    firstEmptyLate = 1'b0;
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
      got[i] = txd;
      held = txd;
      if (i == 0) firstEmpty = txEmpty;
      @(negedge clk);
      if (i == 0) firstEmptyLate = txEmpty;
      if (txd !== held) stableErr++;
    end
  endtask

  task automatic setCfg(input bit sm, input int cl, input int pm, input int st);
    syncMode  = sm;
    charLen   = 2'(cl);
    parityEn  = (pm != 0);
    parityOdd = (pm == 2);
    twoStop   = (st != 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] g1, g2, g3, g4, ex;
    logic fe, fl;
    int len;
    logic [7:0] d;

    repeat (3) @(negedge clk);
    check(txd === 1'b1 && txRdy === 1'b1 && txEmpty === 1'b1, "R1 in reset",
          {txd, txRdy, txEmpty}, 3'b111);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(txd === 1'b1 && txRdy === 1'b1 && txEmpty === 1'b1, "R1 after reset",
          {txd, txRdy, txEmpty}, 3'b111);

    // R5 / R6: second write while full is dropped
    setCfg(0, 3, 0, 0);
    writeByte(8'hC3);
    check(txRdy === 1'b0 && txEmpty === 1'b0, "R5 ready falls", {txRdy, txEmpty}, 2'b00);
    writeByte(8'h3C);
    recvFrame(1, g1, fe, fl);
    check(txRdy === 1'b1, "R5 ready rises after transfer", txRdy, 1);
    recvFrame(9, g2, fe, fl);
    expFrame(8'hC3, 3, 0, 0, 0, ex, len);
    check(({g2[8:0], g1[0]} & lenMask(len)) == (ex & lenMask(len)),
          "R6 held char kept", {g2[8:0], g1[0]}, ex);
    recvFrame(1, g3, fe, fl);
    check(txd === 1'b1 && txEmpty === 1'b1, "R6 ignored write not sent",
          {txd, txEmpty}, 2'b11);

    // R7: back to back without gap
    writeByte(8'h96);
    recvFrame(1, g1, fe, fl);
    writeByte(8'h71);
    recvFrame(9, g2, fe, fl);
    expFrame(8'h96, 3, 0, 0, 0, ex, len);
    check(({g2[8:0], g1[0]} & lenMask(len)) == (ex & lenMask(len)),
          "R7 first char", {g2[8:0], g1[0]}, ex);
    recvFrame(10, g3, fe, fl);
    expFrame(8'h71, 3, 0, 0, 0, ex, len);
    check((g3 & lenMask(len)) == (ex & lenMask(len)), "R7 second char no gap", g3, ex);
    recvFrame(1, g4, fe, fl);

    // R8: clear-to-send withdrawn mid character
    writeByte(8'hE4);
    recvFrame(1, g1, fe, fl);
    ctsN = 1'b1;
    writeByte(8'h2B);
    recvFrame(9, g2, fe, fl);
    expFrame(8'hE4, 3, 0, 0, 0, ex, len);
    check(({g2[8:0], g1[0]} & lenMask(len)) == (ex & lenMask(len)),
          "R8 running char completes", {g2[8:0], g1[0]}, ex);
    recvFrame(4, g3, fe, fl);
    check(g3[3:0] == 4'hF && txRdy === 1'b0 && txEmpty === 1'b0,
          "R8 stalled with char kept", {g3[3:0], txRdy, txEmpty}, 6'b111100);
    ctsN = 1'b0;
    recvFrame(10, g4, fe, fl);
    expFrame(8'h2B, 3, 0, 0, 0, ex, len);
    check((g4 & lenMask(len)) == (ex & lenMask(len)), "R8 kept char sent", g4, ex);
    recvFrame(1, g1, fe, fl);

    // R8: enable low from idle
    txEnable = 1'b0;
    writeByte(8'h5D);
    recvFrame(3, g1, fe, fl);
    check(g1[2:0] == 3'b111 && txRdy === 1'b0, "R8 disabled no start",
          {g1[2:0], txRdy}, 4'b1110);
    txEnable = 1'b1;
    recvFrame(10, g2, fe, fl);
    expFrame(8'h5D, 3, 0, 0, 0, ex, len);
    check((g2 & lenMask(len)) == (ex & lenMask(len)), "R8 sent after enable", g2, ex);
    recvFrame(1, g1, fe, fl);

    // R2 R3 R4: sweep of length, parity and stop settings
    stableErr = 0;
    for (int cl = 0; cl < 4; cl++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int st = 0; st < 2; st++) begin
          setCfg(0, cl, pm, st);
          for (int k = 0; k < 2; k++) begin
            d = 8'(cl * 61 + pm * 23 + st * 97 + k * 150 + 5);
            writeByte(d);
            expFrame(d, cl, pm, st, 0, ex, len);
            recvFrame(len, g1, fe, fl);
            check((g1 & lenMask(len)) == (ex & lenMask(len)),
                  pm == 0 ? "R2 async frame" : "R3 parity frame", g1, ex);
            recvFrame(1, g2, fe, fl);
            if (k == 0)
              check(txd === 1'b1 && txEmpty === 1'b1, "R9 idle after frame",
                    {txd, txEmpty}, 2'b11);
          end
        end
      end
    end
    check(stableErr == 0, "R4 line steady between ticks", stableErr, 0);

    // R10 R11: single sync fill
    setCfg(1, 3, 0, 0);
    syncChar1 = 8'h16;
    dualSync = 1'b0;
    writeByte(8'hA9);
    recvFrame(8, g1, fe, fl);
    expFrame(8'hA9, 3, 0, 0, 1, ex, len);
    check((g1 & lenMask(len)) == (ex & lenMask(len)), "R10 sync data char", g1, ex);
    recvFrame(8, g2, fe, fl);
    expFrame(8'h16, 3, 0, 0, 1, ex, len);
    check((g2 & lenMask(len)) == (ex & lenMask(len)), "R11 sync fill char", g2, ex);
    check(fe === 1'b1 && fl === 1'b0, "R11 empty one-clock pulse", {fe, fl}, 2'b10);
    txEnable = 1'b0;
    recvFrame(1, g3, fe, fl);
    check(txd === 1'b1 && txEmpty === 1'b1, "R9 sync idle when gated",
          {txd, txEmpty}, 2'b11);
    txEnable = 1'b1;

    // R12: dual sync with even parity, 6-bit characters
    setCfg(1, 1, 1, 0);
    dualSync = 1'b1;
    syncChar1 = 8'h2A;
    syncChar2 = 8'h15;
    writeByte(8'h33);
    recvFrame(7, g1, fe, fl);
    expFrame(8'h33, 1, 1, 0, 1, ex, len);
    check((g1 & lenMask(len)) == (ex & lenMask(len)), "R10 sync parity char", g1, ex);
    recvFrame(1, g2, fe, fl);
    writeByte(8'h0E);
    recvFrame(6, g3, fe, fl);
    expFrame(8'h2A, 1, 1, 0, 1, ex, len);
    check(({g3[5:0], g2[0]} & lenMask(len)) == (ex & lenMask(len)),
          "R12 first sync", {g3[5:0], g2[0]}, ex);
    recvFrame(7, g4, fe, fl);
    expFrame(8'h15, 1, 1, 0, 1, ex, len);
    check((g4 & lenMask(len)) == (ex & lenMask(len)), "R12 second sync", g4, ex);
    recvFrame(7, g1, fe, fl);
    expFrame(8'h0E, 1, 1, 0, 1, ex, len);
    check((g1 & lenMask(len)) == (ex & lenMask(len)), "R12 data after pair", g1, ex);
    txEnable = 1'b0;
    recvFrame(1, g2, fe, fl);
    check(txd === 1'b1 && txEmpty === 1'b1, "R12 stops when gated",
          {txd, txEmpty}, 2'b11);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule